// File: doc/BRIEF.md
# SIMT Warp Lane-Issue Sequencer

This block takes one decoded instruction for a whole warp of 32 threads and issues it to a bank of 8 scalar lanes. The warp is split into four slices of 8 threads, and the slices are issued one after another. For each slice the block reports the slice number, the first thread index, an active-lane mask and the operation class, so that downstream lanes know which threads to run. Each lane reports completion through a strobe at the end of its slice.

The operation class sets how many cycles each slice holds the execution resources. Simple operations and 24-bit multiplies take one cycle per slice, so a warp instruction takes 4 cycles. Double-precision work shares one unit across all lanes and takes 2 cycles per slice, or 8 per warp. A full 32-bit multiply takes 4 cycles per slice, or 16 per warp. A valid/ready handshake admits the next instruction only in the final cycle of the current one, so back-to-back instructions run with no idle cycle between them.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset the sequencer is idle. `inReady` is 1, and `sliceValid`, `warpDone`, `laneMask` and `laneDone` are all 0.
- R2: Slices issue in a fixed order: index 0, 1, 2, 3. On each issue cycle `threadBase` equals index×8 and `laneMask` is 8'hFF. On every other cycle `laneMask` is 0.
- R3: Class 2'b00 (simple ALU) occupies 1 cycle per slice. The first slice issues in the cycle after acceptance, and the instruction lasts 4 cycles.
- R4: Class 2'b01 (24-bit integer multiply) occupies 1 cycle per slice and 4 cycles in total.
- R5: Class 2'b10 (full 32-bit integer multiply) occupies 4 cycles per slice. Slices issue 4 cycles apart, and the instruction lasts 16 cycles.
- R6: Class 2'b11 (double precision on the shared unit) occupies 2 cycles per slice. Slices issue 2 cycles apart, and the instruction lasts 8 cycles.
- R7: `inReady` is 1 only when the sequencer is idle or in the last occupancy cycle of the current instruction. `inOp`, `inTag` and `inValid` have no effect while `inReady` is 0.
- R8: `laneDone` is 8'hFF in the last occupancy cycle of each slice and 0 otherwise. `warpDone` pulses in the last cycle of each instruction, and `doneTag` then shows that instruction's tag.
- R9: With `inValid` held high, back-to-back class-00 instructions are accepted exactly once every 4 cycles, and a slice issues on every cycle with no bubble.
- R10: `sliceOp` shows the class of the instruction being issued during all of its occupancy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A warp instruction is offered |
| inOp | input | 2 | Operation class of the offered instruction |
| inTag | input | 4 | Tag of the offered instruction |
| inReady | output | 1 | The sequencer accepts the instruction at this edge |
| sliceValid | output | 1 | A slice is issued this cycle |
| sliceIdx | output | 2 | Index of the current slice |
| threadBase | output | 5 | First thread index of the current slice |
| laneMask | output | 8 | Active lanes of the issued slice |
| sliceOp | output | 2 | Operation class of the current instruction |
| laneDone | output | 8 | Per-lane completion strobes |
| warpDone | output | 1 | Last occupancy cycle of the instruction |
| doneTag | output | 4 | Tag of the instruction that is finishing |

## Verification
Each of the four classes is run by itself from idle, and the cycle of every slice issue, lane completion and warp completion is compared with the class's occupancy. This separates a 1-, 2- and 4-cycle slice length and catches slice-order or thread-base errors. A streak of back-to-back simple instructions with `inValid` held high checks that acceptance happens only in the final cycle and that no bubble appears. A long multiply is then offered new class and tag values while busy, to show that inputs are ignored until ready.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;

  typedef enum logic [1:0] {
    OP_ALU    = 2'b00,
    OP_IMUL24 = 2'b01,
    OP_IMUL32 = 2'b10,
    OP_DFP    = 2'b11
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // instruction accepted at this edge
    logic issue;    // first occupancy cycle of a slice
    logic retire;   // last occupancy cycle of a slice
    logic warpEnd;  // last occupancy cycle of the instruction
  } seqStrobe_t;

endpackage

// File: rtl/warp_issue_ctrl.sv
module warp_issue_ctrl
  import warp_issue_pkg::*;
#(
  parameter int SLICES    = 4,
  parameter int MUL32_CYC = 4,
  parameter int DP_CYC    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic [1:0]                inOp,
  output logic                      inReady,
  output seqStrobe_t                strobe,
  output logic [$clog2(SLICES)-1:0] sliceIdx
);

  localparam int SLICE_W = $clog2(SLICES);
  localparam int MAX_OCC = (MUL32_CYC > DP_CYC) ? ((MUL32_CYC > 2) ? MUL32_CYC : 2)
                                                : ((DP_CYC > 2) ? DP_CYC : 2);
  localparam int OCC_W   = $clog2(MAX_OCC);

  logic               busy;
  logic [SLICE_W-1:0] sliceCnt;
  logic [OCC_W-1:0]   subCnt;
  logic [OCC_W-1:0]   occM1;
  logic [OCC_W-1:0]   occIn;
  logic               subEnd;
  logic               lastSlice;
  logic               accept;

  always_comb begin
    case (opClass_e'(inOp))
      OP_IMUL32: occIn = OCC_W'(MUL32_CYC - 1);
      OP_DFP:    occIn = OCC_W'(DP_CYC - 1);
      default:   occIn = '0;
    endcase
  end

  assign subEnd    = (subCnt == occM1);
  assign lastSlice = (sliceCnt == SLICE_W'(SLICES - 1));
  assign inReady   = !busy || (subEnd && lastSlice);
  assign accept    = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sliceCnt <= '0;
      subCnt   <= '0;
      occM1    <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      sliceCnt <= '0;
      subCnt   <= '0;
      occM1    <= occIn;
    end else if (busy) begin
      if (subEnd) begin
        subCnt <= '0;
        if (lastSlice) busy <= 1'b0;
        else           sliceCnt <= sliceCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  assign strobe.load    = accept;
  assign strobe.issue   = busy && (subCnt == '0);
  assign strobe.retire  = busy && subEnd;
  assign strobe.warpEnd = busy && subEnd && lastSlice;
  assign sliceIdx       = sliceCnt;

  // R2: the end of a non-final slice is followed by the issue of the next slice
  p_slice_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && subEnd && !lastSlice) |=>
      (strobe.issue && sliceCnt == SLICE_W'($past(sliceCnt) + 1'b1)));

  // R1: an idle sequencer issues and retires nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(strobe.issue || strobe.retire));

endmodule

// File: rtl/warp_issue_dp.sv
module warp_issue_dp
  import warp_issue_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int SLICES = 4,
  parameter int TAG_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  seqStrobe_t                       strobe,
  input  logic [$clog2(SLICES)-1:0]        sliceIdxIn,
  input  logic [1:0]                       inOp,
  input  logic [TAG_W-1:0]                 inTag,
  output logic                             sliceValid,
  output logic [$clog2(SLICES)-1:0]        sliceIdx,
  output logic [$clog2(LANES*SLICES)-1:0]  threadBase,
  output logic [LANES-1:0]                 laneMask,
  output logic [1:0]                       sliceOp,
  output logic [LANES-1:0]                 laneDone,
  output logic                             warpDone,
  output logic [TAG_W-1:0]                 doneTag
);

  localparam int THR_W = $clog2(LANES * SLICES);

  logic [1:0]       opReg;
  logic [TAG_W-1:0] tagReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opReg  <= '0;
      tagReg <= '0;
    end else if (strobe.load) begin
      opReg  <= inOp;
      tagReg <= inTag;
    end
  end

  assign sliceValid = strobe.issue;
  assign sliceIdx   = sliceIdxIn;
  assign threadBase = THR_W'(sliceIdxIn) * THR_W'(LANES);
  assign laneMask   = strobe.issue  ? '1 : '0;
  assign laneDone   = strobe.retire ? '1 : '0;
  assign sliceOp    = opReg;
  assign warpDone   = strobe.warpEnd;
  assign doneTag    = tagReg;

  // R8: the warp ends only together with the completion of a slice
  p_end_with_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warpDone |-> (laneDone != '0));

endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import warp_issue_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int LANES     = 8,
  parameter int MUL32_CYC = 4,
  parameter int DP_CYC    = 2,
  parameter int TAG_W     = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  inValid,
  input  logic [1:0]                            inOp,
  input  logic [TAG_W-1:0]                      inTag,
  output logic                                  inReady,
  output logic                                  sliceValid,
  output logic [$clog2(WARP_SIZE/LANES)-1:0]    sliceIdx,
  output logic [$clog2(WARP_SIZE)-1:0]          threadBase,
  output logic [LANES-1:0]                      laneMask,
  output logic [1:0]                            sliceOp,
  output logic [LANES-1:0]                      laneDone,
  output logic                                  warpDone,
  output logic [TAG_W-1:0]                      doneTag
);

  localparam int SLICES  = WARP_SIZE / LANES;
  localparam int SLICE_W = $clog2(SLICES);

  seqStrobe_t         strobe;
  logic [SLICE_W-1:0] ctrlSlice;

  warp_issue_ctrl #(
    .SLICES(SLICES), .MUL32_CYC(MUL32_CYC), .DP_CYC(DP_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOp(inOp),
    .inReady(inReady), .strobe(strobe), .sliceIdx(ctrlSlice)
  );

  warp_issue_dp #(
    .LANES(LANES), .SLICES(SLICES), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sliceIdxIn(ctrlSlice),
    .inOp(inOp), .inTag(inTag), .sliceValid(sliceValid), .sliceIdx(sliceIdx),
    .threadBase(threadBase), .laneMask(laneMask), .sliceOp(sliceOp),
    .laneDone(laneDone), .warpDone(warpDone), .doneTag(doneTag)
  );

  // R8: the finishing cycle always admits the next instruction
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warpDone |-> inReady);

  // R3: an accepted instruction issues slice 0 in the next cycle
  p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> (sliceValid && sliceIdx == '0));

  // R7: the reported class cannot change while input is refused
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inReady |=> $stable(sliceOp));

  // R5, R6: multi-cycle classes leave a gap after each slice issue
  p_long_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sliceValid && ((sliceOp == OP_IMUL32 && MUL32_CYC > 1) ||
                    (sliceOp == OP_DFP && DP_CYC > 1))) |=> !sliceValid);

endmodule

// File: tb/warp_issue_seq_tb.sv
module warp_issue_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       inValid;
  logic [1:0] inOp;
  logic [3:0] inTag;
  logic       inReady;
  logic       sliceValid;
  logic [1:0] sliceIdx;
  logic [4:0] threadBase;
  logic [7:0] laneMask;
  logic [1:0] sliceOp;
  logic [7:0] laneDone;
  logic       warpDone;
  logic [3:0] doneTag;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  warp_issue_seq u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inOp(inOp), .inTag(inTag),
    .inReady(inReady), .sliceValid(sliceValid), .sliceIdx(sliceIdx),
    .threadBase(threadBase), .laneMask(laneMask), .sliceOp(sliceOp),
    .laneDone(laneDone), .warpDone(warpDone), .doneTag(doneTag)
  );

  localparam int NVEC = 8;
  localparam logic [1:0] V_OP  [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b11, 2'b10, 2'b01};
  localparam logic [3:0] V_TAG [NVEC] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int occFor(input logic [1:0] op);
    case (op)
      2'b10:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic string reqFor(input logic [1:0] op);
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // runs one instruction from idle; optionally offers junk while busy
  task automatic runOne(input logic [1:0] op, input logic [3:0] tag, input bit junk);
    int occ = occFor(op);
    int total = 4 * occ;
    int sliceBad = 0, doneBad = 0, opBad = 0, readyBad = 0, wdBad = 0;
    int issues = 0, tagSeen = -1;
    @(negedge clk);
    chk(inReady == 1'b1, "R7", "ready when idle", int'(inReady), 1);
    inValid = 1'b1; inOp = op; inTag = tag;
    @(posedge clk);
    for (int c = 1; c <= total; c++) begin
      @(negedge clk);
      if (c == 1) inValid = 1'b0;
      if (junk && c == 2) begin inValid = 1'b1; inOp = 2'b00; inTag = ~tag; end
      if (junk && c == total - 1) inValid = 1'b0;
      begin
        bit expIssue = ((c - 1) % occ) == 0;
        int expSlice = (c - 1) / occ;
        bit expRetire = (c % occ) == 0;
        if (sliceValid !== expIssue) sliceBad++;
        if (expIssue) begin
          issues++;
          if (sliceIdx !== 2'(expSlice) || threadBase !== 5'(expSlice * 8) || laneMask !== 8'hFF)
            sliceBad++;
        end else if (laneMask !== 8'h00) sliceBad++;
        if ((laneDone === 8'hFF) !== expRetire || (!expRetire && laneDone !== 8'h00)) doneBad++;
        if (sliceOp !== op) opBad++;
        if (inReady !== (c == total)) readyBad++;
        if (warpDone !== (c == total)) wdBad++;
        if (c == total) tagSeen = int'(doneTag);
      end
    end
    chk(sliceBad == 0 && issues == 4, reqFor(op), "slice issue timing", sliceBad, 0);
    chk(sliceBad == 0, "R2", "slice order/base/mask", sliceBad, 0);
    chk(doneBad == 0, "R8", "laneDone per slice", doneBad, 0);
    chk(wdBad == 0, reqFor(op), "warpDone cycle", wdBad, 0);
    chk(tagSeen == int'(tag), "R8", "doneTag", tagSeen, int'(tag));
    chk(opBad == 0, "R10", "sliceOp held", opBad, 0);
    chk(readyBad == 0, "R7", "ready only at end", readyBad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; inValid = 1'b0; inOp = 2'b00; inTag = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    chk(sliceValid == 1'b0 && warpDone == 1'b0, "R1", "no slice/done after reset",
        int'({sliceValid, warpDone}), 0);
    chk(laneMask == 8'h00 && laneDone == 8'h00, "R1", "masks after reset",
        int'({laneMask, laneDone}), 0);

    // table walk: every class from idle
    for (int i = 0; i < NVEC; i++) runOne(V_OP[i], V_TAG[i], 1'b0);

    // R7: junk offered while a 32-bit multiply is busy is ignored
    runOne(2'b10, 4'd9, 1'b1);

    // R9: back-to-back simple instructions, inValid held high
    begin
      int bubbles = 0, readyBad = 0, doneBad = 0, tagBad = 0, idxBad = 0;
      logic [3:0] t = 4'd10;
      @(negedge clk);
      inValid = 1'b1; inOp = 2'b00; inTag = t;
      for (int c = 1; c <= 12; c++) begin
        @(negedge clk);
        if (sliceValid !== 1'b1) bubbles++;
        if (sliceIdx !== 2'((c - 1) % 4)) idxBad++;
        if (inReady !== ((c % 4) == 0)) readyBad++;
        if (warpDone !== ((c % 4) == 0)) doneBad++;
        if ((c % 4) == 0) begin
          if (doneTag !== 4'(10 + (c / 4) - 1)) tagBad++;
          t = t + 4'd1;
          inTag = t;
          if (c == 12) inValid = 1'b0;
        end
      end
      chk(bubbles == 0, "R9", "no bubble back-to-back", bubbles, 0);
      chk(readyBad == 0, "R9", "accept every 4 cycles", readyBad, 0);
      chk(doneBad == 0, "R9", "warpDone every 4 cycles", doneBad, 0);
      chk(tagBad == 0, "R8", "doneTag back-to-back", tagBad, 0);
      chk(idxBad == 0, "R2", "slice order back-to-back", idxBad, 0);
      @(negedge clk);
      chk(sliceValid == 1'b0 && inReady == 1'b1, "R1", "idle after stream",
          int'({sliceValid, inReady}), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule